// File: doc/BRIEF.md
# Triggered Sample Frame Serializer

This block turns first-level trigger strobes from a front-end readout chip into serial data frames. Each accepted trigger produces one frame of 140 eight-bit slots: a 12-slot digital header, then the 128 channel samples in multiplexed order, channel 0 first. The samples come from an external sample memory. The block drives the read address and takes the read data back in the same cycle. The frame leaves the block one bit per clock, together with a frame-valid flag. At the nominal 160 Mbit/s bit rate, a frame lasts 7 µs. That is shorter than the 10 µs mean trigger spacing at 100 kHz.

Triggers can arrive in bursts. Each trigger's pipeline address and error flag are captured into a four-entry queue when the trigger arrives. The serializer takes entries from the queue one at a time. If a trigger finds the queue full, it is dropped and a sticky overflow flag is raised. A synchronous reset empties the queue, clears the flag and stops any frame in progress.

Top module: `frame_ser`

## Requirements
- R1: Every frame is exactly 1120 bits long. `frame_vld_o` stays high for 1120 consecutive clocks and is low on the clock after the last bit.
- R2: Header slots 0, 1 and 2 carry the sync bytes 0xF6, 0x28 and 0xA7, in that order.
- R3: Header slot 3 carries the 8-bit pipeline address captured with the trigger. Slot 4 carries the trigger's error bit in bit 7, with bits 6..0 zero. Slots 5 to 11 are zero.
- R4: Slots 12 to 139 carry channels 0 to 127 in order. Each channel is read by placing its number on `mem_raddr_o` and taking `mem_rdata_i` combinationally in the same cycle.
- R5: Within each 8-bit slot, bit 7 is sent first and bit 0 last.
- R6: While no frame is being sent, `ser_o` is 0 and `frame_vld_o` is 0.
- R7: A trigger sampled at a clock edge while the block is idle with an empty queue makes `frame_vld_o` rise after the next clock edge. The first frame bit is therefore present in the second cycle after the trigger's edge.
- R8: Triggers received during a frame are queued in arrival order, up to four. Each queued frame starts after exactly one idle clock following the previous frame.
- R9: A trigger that finds four pending entries, with no frame starting in that cycle, is dropped and sets `ovf_o`. `ovf_o` then stays high until reset.
- R10: A trigger that arrives when the queue is full, in the same cycle that an entry leaves the queue to start a frame, is accepted without overflow.
- R11: A synchronous reset, `rst` high, empties the queue, clears `ovf_o` and `frame_vld_o`, and aborts any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger strobe, one clock per trigger |
| trig_paddr_i | input | 8 | Pipeline address captured with the trigger |
| trig_err_i | input | 1 | Error bit captured with the trigger |
| mem_raddr_o | output | 7 | Channel number sent to the sample memory |
| mem_rdata_i | input | 8 | Sample memory read data, same cycle as the address |
| ser_o | output | 1 | Serial frame data |
| frame_vld_o | output | 1 | High while frame bits are on `ser_o` |
| ovf_o | output | 1 | Sticky flag for a trigger dropped on a full queue |

## Verification
Two things can happen in the same clock: a new trigger pushes into the queue while the serializer pops an entry to start its next frame. The bench fills the queue to four entries during a running frame. It then raises a trigger in the single idle cycle after that frame ends, which is the cycle where the pop happens. The test passes only if `ovf_o` stays low and that trigger's pipeline address appears in the fifth queued frame, in order. A companion test pushes onto a full queue while a frame is still active, which must raise the flag and lose that frame.

// File: rtl/frame_pkg.sv
package frame_pkg;
   localparam int PADDR_W = 8;

   typedef struct packed {
      logic               err;
      logic [PADDR_W-1:0] paddr;
   } trig_info_t;

   localparam int INFO_W = $bits(trig_info_t);
endpackage

// File: rtl/trig_fifo.sv
module trig_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 9
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         empty_o,
   output logic         ovf_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] cnt;
   logic          full, accept;

   assign full    = (cnt == CW'(DEPTH));
   assign empty_o = (cnt == '0);
   assign accept  = push_i && (!full || pop_i);
   assign dout_o  = store[rd_ptr];

   function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (accept && (wr_ptr == PW'(i)))
            store[i] <= din_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
         ovf_o  <= 1'b0;
      end else begin
         if (accept) wr_ptr <= wrap_inc(wr_ptr);
         if (pop_i)  rd_ptr <= wrap_inc(rd_ptr);
         case ({accept, pop_i})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
         if (push_i && full && !pop_i)
            ovf_o <= 1'b1;
      end
   end
endmodule

// File: rtl/slot_mux.sv
module slot_mux
   import frame_pkg::*;
#(
   parameter int          SLOT_W     = 8,
   parameter int          SYNC_SLOTS = 3,
   parameter int          HDR_SLOTS  = 12,
   parameter int          SC_W       = 8,
   parameter int          CH_W       = 7,
   parameter logic [SYNC_SLOTS*SLOT_W-1:0] SYNC_WORD = 24'hF628A7
) (
   input  logic [SC_W-1:0]   slot_i,
   input  trig_info_t        info_i,
   input  logic [SLOT_W-1:0] mem_rdata_i,
   output logic [CH_W-1:0]   mem_raddr_o,
   output logic [SLOT_W-1:0] byte_o
);
   assign mem_raddr_o = CH_W'(slot_i - SC_W'(HDR_SLOTS));

   always_comb begin
      byte_o = '0;
      if (slot_i < SC_W'(SYNC_SLOTS))
         byte_o = SYNC_WORD[(SYNC_SLOTS - 1 - int'(slot_i)) * SLOT_W +: SLOT_W];
      else if (slot_i == SC_W'(SYNC_SLOTS))
         byte_o = SLOT_W'(info_i.paddr);
      else if (slot_i == SC_W'(SYNC_SLOTS + 1))
         byte_o = {info_i.err, {(SLOT_W-1){1'b0}}};
      else if (slot_i >= SC_W'(HDR_SLOTS))
         byte_o = mem_rdata_i;
   end
endmodule

// File: rtl/frame_engine.sv
module frame_engine
   import frame_pkg::*;
#(
   parameter int SLOT_W    = 8,
   parameter int FR_SLOTS  = 140,
   parameter int SC_W      = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              q_empty_i,
   input  trig_info_t        q_head_i,
   input  logic [SLOT_W-1:0] slot_byte_i,
   output logic              pop_o,
   output logic [SC_W-1:0]   nxt_slot_o,
   output trig_info_t        info_o,
   output logic              ser_o,
   output logic              vld_o
);
   localparam int BC_W = $clog2(SLOT_W);

   logic              active;
   logic [SC_W-1:0]   slot;
   logic [BC_W-1:0]   bitc;
   logic [SLOT_W-1:0] sh, sh_nx;
   logic              out_bit, last_bit, last_slot;

   if (MSB_FIRST) begin : g_msb
      assign out_bit = sh[SLOT_W-1];
      assign sh_nx   = {sh[SLOT_W-2:0], 1'b0};
   end else begin : g_lsb
      assign out_bit = sh[0];
      assign sh_nx   = {1'b0, sh[SLOT_W-1:1]};
   end

   assign pop_o      = !active && !q_empty_i;
   assign last_bit   = (bitc == BC_W'(SLOT_W - 1));
   assign last_slot  = (slot == SC_W'(FR_SLOTS - 1));
   assign nxt_slot_o = active ? slot + SC_W'(1) : '0;
   assign ser_o      = active & out_bit;
   assign vld_o      = active;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         slot   <= '0;
         bitc   <= '0;
         sh     <= '0;
         info_o <= '0;
      end else if (pop_o) begin
         active <= 1'b1;
         slot   <= '0;
         bitc   <= '0;
         sh     <= slot_byte_i;
         info_o <= q_head_i;
      end else if (active) begin
         if (last_bit) begin
            bitc <= '0;
            if (last_slot) begin
               active <= 1'b0;
               sh     <= '0;
            end else begin
               slot <= nxt_slot_o;
               sh   <= slot_byte_i;
            end
         end else begin
            bitc <= bitc + BC_W'(1);
            sh   <= sh_nx;
         end
      end
   end
endmodule

// File: rtl/frame_ser.sv
module frame_ser
   import frame_pkg::*;
#(
   parameter int N_CH       = 128,
   parameter int HDR_SLOTS  = 12,
   parameter int SLOT_W     = 8,
   parameter int SYNC_SLOTS = 3,
   parameter int QDEPTH     = 4,
   parameter bit MSB_FIRST  = 1'b1,
   parameter logic [SYNC_SLOTS*SLOT_W-1:0] SYNC_WORD = 24'hF628A7
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    trig_i,
   input  logic [PADDR_W-1:0]      trig_paddr_i,
   input  logic                    trig_err_i,
   output logic [$clog2(N_CH)-1:0] mem_raddr_o,
   input  logic [SLOT_W-1:0]       mem_rdata_i,
   output logic                    ser_o,
   output logic                    frame_vld_o,
   output logic                    ovf_o
);
   localparam int FR_SLOTS   = HDR_SLOTS + N_CH;
   localparam int FRAME_BITS = FR_SLOTS * SLOT_W;
   localparam int SC_W       = $clog2(FR_SLOTS + 1);
   localparam int CH_W       = $clog2(N_CH);

   if (SLOT_W != PADDR_W) begin : g_chk_w
      $error("frame_ser: slot width must equal pipeline address width");
   end
   if (SYNC_SLOTS < 1 || HDR_SLOTS < SYNC_SLOTS + 2) begin : g_chk_hdr
      $error("frame_ser: header too short for sync, address and error slots");
   end
   if (N_CH < 2 || QDEPTH < 1) begin : g_chk_sz
      $error("frame_ser: channel count or queue depth out of range");
   end

   trig_info_t        push_info, head_info, cur_info;
   logic              q_empty, pop;
   logic [SC_W-1:0]   nxt_slot;
   logic [SLOT_W-1:0] slot_byte;

   assign push_info = '{err: trig_err_i, paddr: trig_paddr_i};

   trig_fifo #(.DEPTH(QDEPTH), .W(INFO_W)) u_queue (
      .clk(clk), .rst(rst),
      .push_i(trig_i), .din_i(push_info),
      .pop_i(pop), .dout_o(head_info),
      .empty_o(q_empty), .ovf_o(ovf_o)
   );

   slot_mux #(
      .SLOT_W(SLOT_W), .SYNC_SLOTS(SYNC_SLOTS), .HDR_SLOTS(HDR_SLOTS),
      .SC_W(SC_W), .CH_W(CH_W), .SYNC_WORD(SYNC_WORD)
   ) u_mux (
      .slot_i(nxt_slot), .info_i(cur_info), .mem_rdata_i(mem_rdata_i),
      .mem_raddr_o(mem_raddr_o), .byte_o(slot_byte)
   );

   frame_engine #(
      .SLOT_W(SLOT_W), .FR_SLOTS(FR_SLOTS), .SC_W(SC_W), .MSB_FIRST(MSB_FIRST)
   ) u_eng (
      .clk(clk), .rst(rst),
      .q_empty_i(q_empty), .q_head_i(head_info), .slot_byte_i(slot_byte),
      .pop_o(pop), .nxt_slot_o(nxt_slot), .info_o(cur_info),
      .ser_o(ser_o), .vld_o(frame_vld_o)
   );
endmodule

// File: rtl/frame_ser_chk.sv
module frame_ser_chk #(
   parameter int FRAME_BITS = 1120
) (
   input logic clk,
   input logic rst,
   input logic trig,
   input logic ser,
   input logic vld,
   input logic ovf
);
   localparam int RW = $clog2(FRAME_BITS + 2);
   logic [RW-1:0] run;

   always_ff @(posedge clk) begin
      if (rst)      run <= '0;
      else if (vld) run <= run + RW'(1);
      else          run <= '0;
   end

   a_r1_frame_len: assert property (@(posedge clk) disable iff (rst)
      ($fell(vld) && !$past(rst)) |-> (run == RW'(FRAME_BITS)));

   a_r1_no_long_frame: assert property (@(posedge clk) disable iff (rst)
      vld |-> (run < RW'(FRAME_BITS)));

   a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
      !vld |-> !ser);

   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);

   a_r9_ovf_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf) |-> $past(trig));

   a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> (!vld && !ovf));
endmodule

bind frame_ser frame_ser_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
   .clk(clk), .rst(rst), .trig(trig_i),
   .ser(ser_o), .vld(frame_vld_o), .ovf(ovf_o)
);

// File: tb/frame_ser_test.sv
module frame_ser_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       trig = 1'b0;
   logic [7:0] paddr = '0;
   logic       err = 1'b0;
   logic [6:0] raddr;
   logic [7:0] rdata;
   logic       ser, vld, ovf;
   logic [7:0] seed = '0;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [7:0] cap [140];
   int len_bad, gap;
   logic tail_vld, tail_ser;

   always #2 clk = ~clk;

   frame_ser uut (
      .clk(clk), .rst(rst), .trig_i(trig), .trig_paddr_i(paddr),
      .trig_err_i(err), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
      .ser_o(ser), .frame_vld_o(vld), .ovf_o(ovf)
   );

   function automatic logic [7:0] ch_val(int ch, logic [7:0] s);
      logic [7:0] t;
      t = 8'(ch * 7 + int'(s));
      return t ^ 8'hC3;
   endfunction

   assign rdata = ch_val(int'(raddr), seed);

   function automatic logic [7:0] exp_slot(int s, logic [7:0] pa, logic e, logic [7:0] sd);
      case (s)
         0: return 8'hF6;
         1: return 8'h28;
         2: return 8'hA7;
         3: return pa;
         4: return {e, 7'b0};
         default: return (s < 12) ? 8'h00 : ch_val(s - 12, sd);
      endcase
   endfunction

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "watchdog expired", cyc, 150000);
         finish_run();
      end
   end

   // called at a negedge; raises trigger for one clock
   task automatic fire(input logic [7:0] pa, input logic e);
      trig = 1'b1; paddr = pa; err = e;
      @(negedge clk);
      trig = 1'b0;
   endtask

   // called at a negedge; waits for a frame and captures it
   task automatic get_frame();
      gap = 0; len_bad = 0;
      while (!vld && gap < 3000) begin
         @(negedge clk);
         gap++;
      end
      for (int i = 0; i < 1120; i++) begin
         if (!vld) len_bad++;
         cap[i/8] = {cap[i/8][6:0], ser};
         @(negedge clk);
      end
      tail_vld = vld;
      tail_ser = ser;
   endtask

   task automatic check_frame(input logic [7:0] pa, input logic e, input string tag);
      int sb = 0, hb = 0, db = 0, first = -1;
      chk(len_bad == 0 && !tail_vld, {tag, " R1 frame length"}, len_bad, 0);
      chk(!tail_ser, {tag, " R6 idle output after frame"}, int'(tail_ser), 0);
      for (int s = 0; s < 140; s++) begin
         if (cap[s] !== exp_slot(s, pa, e, seed)) begin
            if (s < 3) sb++; else if (s < 12) hb++; else db++;
            if (first < 0) first = s;
         end
      end
      chk(sb == 0, {tag, " R2 sync bytes"}, sb, 0);
      chk(hb == 0, {tag, " R3 header fields"}, (first >= 0) ? int'(cap[first]) : 0,
          (first >= 0) ? int'(exp_slot(first, pa, e, seed)) : 0);
      chk(db == 0, {tag, " R4 R5 channel data"}, (first >= 0) ? int'(cap[first]) : 0,
          (first >= 0) ? int'(exp_slot(first, pa, e, seed)) : 0);
   endtask

   // vectors: {seed, pipeline address, error bit}
   localparam logic [16:0] VEC [4] = '{
      {8'h00, 8'h00, 1'b0},
      {8'h11, 8'hFF, 1'b1},
      {8'h80, 8'h3C, 1'b0},
      {8'hFE, 8'h81, 1'b1}
   };

   initial begin
      repeat (3) @(negedge clk);
      chk(!vld && !ser && !ovf, "R11 R6 reset state", {vld, ser, ovf}, 0);
      rst = 1'b0;
      @(negedge clk);

      for (int v = 0; v < 4; v++) begin
         seed = VEC[v][16:9];
         fork
            fire(VEC[v][8:1], VEC[v][0]);
            get_frame();
         join
         chk(gap == 2, "R7 start latency", gap, 2);
         check_frame(VEC[v][8:1], VEC[v][0], "vector");
         repeat (5) @(negedge clk);
      end

      // queue in order plus push on the pop cycle of a full queue
      seed = 8'h42;
      fork
         get_frame();
         begin
            fire(8'h10, 1'b0);
            fire(8'h11, 1'b1);
            fire(8'h12, 1'b0);
            fire(8'h13, 1'b1);
            fire(8'h14, 1'b0);
         end
      join
      check_frame(8'h10, 1'b0, "R8 frame A");
      fork
         get_frame();
         fire(8'h15, 1'b1);
      join
      chk(gap == 1, "R8 one idle clock between frames", gap, 1);
      chk(!ovf, "R10 push on pop cycle accepted", int'(ovf), 0);
      check_frame(8'h11, 1'b1, "R8 frame B");
      for (int k = 2; k < 6; k++) begin
         get_frame();
         chk(gap == 1, "R8 queued gap", gap, 1);
         check_frame(8'(8'h10 + k), k[0], "R8 R10 queued frame");
      end
      repeat (1300) @(negedge clk);
      chk(!vld, "R8 queue drained", int'(vld), 0);

      // overflow while a frame is running
      seed = 8'h07;
      fork
         get_frame();
         begin
            fire(8'h20, 1'b0);
            fire(8'h21, 1'b0);
            fire(8'h22, 1'b0);
            fire(8'h23, 1'b0);
            fire(8'h24, 1'b0);
            fire(8'h25, 1'b1);
            chk(ovf, "R9 overflow raised", int'(ovf), 1);
         end
      join
      check_frame(8'h20, 1'b0, "R9 frame 0");
      for (int k = 1; k < 5; k++) begin
         get_frame();
         check_frame(8'(8'h20 + k), 1'b0, "R9 kept frame");
      end
      begin
         int seen = 0;
         repeat (1300) begin
            @(negedge clk);
            if (vld) seen++;
         end
         chk(seen == 0, "R9 dropped trigger makes no frame", seen, 0);
      end
      chk(ovf, "R9 overflow sticky", int'(ovf), 1);

      // reset during a frame with one trigger queued
      fire(8'h30, 1'b0);
      repeat (40) @(negedge clk);
      fire(8'h31, 1'b0);
      chk(vld, "R11 frame running before reset", int'(vld), 1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      chk(!vld && !ser && !ovf, "R11 reset clears outputs", {vld, ser, ovf}, 0);
      begin
         int seen = 0;
         repeat (1300) begin
            @(negedge clk);
            if (vld || ser) seen++;
         end
         chk(seen == 0, "R11 queue emptied by reset", seen, 0);
      end

      finish_run();
   end
endmodule